// File: doc/BRIEF.md
# Eight-Point Modulo-257 Number-Theoretic Transform

This block computes an eight-point number-theoretic transform over the integers modulo 257. It takes eight 9-bit words and returns eight 9-bit words. Output k is the sum over j of x[j]·4^(j·k) mod 257, because 4 is a primitive eighth root of unity modulo 257. The datapath is three layers of four add/subtract butterflies in decimation-in-frequency form. It contains no multipliers.

Inside the block, each value c is carried in the complemented form C = (256 − c) mod 257. In this form, multiplying by 2^k reduces to a rotation of the low eight bits by k places, with the wrapped bits inverted. The ninth bit is set only for the value zero, and a zero passes through a twiddle unchanged. Every twiddle in the eight-point case is a power of two, so the twiddles cost no more than wiring and inverters.

Parameters choose the following:
- whether the block converts to and from this form at its input and output edges;
- whether the outputs come out in natural or in bit-reversed order;
- whether an output register follows the combinational network.

It is meant as the leaf of a larger transform, or as a standalone small transform stage.

Top module: `ntt8_transform`

## Requirements
- R1: With plain inputs and outputs in natural order, output word k equals Σ_j x[j]·4^(j·k) mod 257 for every input word in 0..256.
- R2: Word j of `in_data` and of `out_data` occupies bits [9j+8:9j].
- R3: With NATURAL_ORDER=1, output slot k holds transform term k. With NATURAL_ORDER=0, slot i holds term rev(i), where rev reverses the three index bits (slot 1 holds term 4, slot 3 holds term 6).
- R4: With ENC_IN=0, each input word is taken as already complemented (C = (256 − c) mod 257, so value 0 is 256 and value 256 is 0). With ENC_OUT=0, each output word is given in that same form.
- R5: The value 256 (−1) and the value 0 are handled exactly in every input position.
- R6: Every output word lies in 0..256 whenever `out_valid` is high.
- R7: With OUT_REG=1, `out_valid` and the result appear on the first clock edge after `in_valid` is high. With OUT_REG=0, they follow the inputs in the same cycle.
- R8: With OUT_REG=1, `out_data` holds its value in any cycle where `in_valid` is low, whatever `in_data` carries.
- R9: While `rst_n` is low, the output register clears: `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_data | input | 72 | Eight 9-bit input words, word j at [9j+8:9j] |
| out_valid | output | 1 | Output vector is valid |
| out_data | output | 72 | Eight 9-bit transform outputs |

## Verification
The bench places the value 256 in each input position in turn, and also in all positions at once. A wrong fold in the subtract path, or a rotation that mishandled the top bit, would then give a result one off, or 257 in place of 0. Impulses at each position separate the twiddle exponents: a rotation of the wrong amount or wrong direction would put a wrong power of 4 into a single output. A second instance with complemented edges and bit-reversed order checks the ordering and the edge conversions against the same reference. Idle cycles with junk on the input show whether the register reloads when it should not.

// File: rtl/ntt8_pkg.sv
// Package: shared sizes, types and modulo-257 helper functions.
// Assumes every word is in 0..256 and internal words are complemented
// (C = 256 - c), so bit 8 set means the value zero.
package ntt8_pkg;
    localparam int NPTS  = 8;
    localparam int LOGN  = $clog2(NPTS);
    localparam int WW    = 9;
    localparam int HALF  = NPTS / 2;

    typedef logic [WW-1:0]            word_t;
    typedef logic [NPTS-1:0][WW-1:0]  vec_t;

    // Plain value <-> complemented form (self-inverse on 0..256).
    function automatic word_t flip_enc(word_t v);
        return word_t'(9'd256 - v);
    endfunction

    // Sum in complemented form: A + B - 256, folded once into 0..256.
    function automatic word_t enc_add(word_t a, word_t b);
        logic [WW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 10'd256) return word_t'(s - 10'd256);
        return word_t'(s + 10'd1);
    endfunction

    // Difference in complemented form: A - B + 256, folded once into 0..256.
    function automatic word_t enc_sub(word_t a, word_t b);
        logic [WW:0] t;
        t = {1'b0, a} + 10'd256 - {1'b0, b};
        if (t >= 10'd257) return word_t'(t - 10'd257);
        return t[WW-1:0];
    endfunction

    // Multiply by 2^k in complemented form: rotate low byte, invert wrapped bits.
    function automatic word_t enc_rot(word_t c, int unsigned k);
        logic [15:0] dbl;
        logic [7:0]  wrap_mask;
        dbl       = {c[7:0], c[7:0]} << k;
        wrap_mask = ~(8'hFF << k);
        if (c[8]) return c;
        return {1'b0, dbl[15:8] ^ wrap_mask};
    endfunction

    // Reverse the LOGN index bits.
    function automatic int bit_rev(int v);
        int r;
        r = 0;
        for (int b = 0; b < LOGN; b++) r = (r << 1) | ((v >> b) & 1);
        return r;
    endfunction
endpackage

// File: rtl/ntt8_butterfly.sv
// Module: one decimation-in-frequency butterfly in complemented form.
// top = a + b; bot = (a - b) * 2^SHIFT. Assumes inputs in 0..256, SHIFT < 8.
module ntt8_butterfly
    import ntt8_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  word_t a,
    input  word_t b,
    output word_t top,
    output word_t bot
);
    word_t diff;

    // Sum and difference, each folded back into range.
    always_comb begin
        top  = enc_add(a, b);
        diff = enc_sub(a, b);
    end

    // Twiddle by rotation; a zero shift is plain wiring.
    generate
        if (SHIFT == 0) begin : g_plain
            assign bot = diff;
        end else begin : g_rot
            assign bot = enc_rot(diff, SHIFT);
        end
    endgenerate
endmodule

// File: rtl/ntt8_layer.sv
// Module: one layer of HALF butterflies. STAGE 0 pairs words 4 apart,
// STAGE 1 pairs words 2 apart, STAGE 2 adjacent words. Twiddle exponent of
// butterfly at offset p in its group is p * 2^STAGE (root 4 -> shift 2x that).
module ntt8_layer
    import ntt8_pkg::*;
#(
    parameter int STAGE = 0
) (
    input  vec_t din,
    output vec_t dout
);
    localparam int SPAN = NPTS >> (STAGE + 1);

    generate
        for (genvar bf = 0; bf < HALF; bf++) begin : g_bf
            localparam int GRP   = bf / SPAN;
            localparam int POS   = bf % SPAN;
            localparam int LO    = GRP * 2 * SPAN + POS;
            localparam int HI    = LO + SPAN;
            localparam int SHAMT = 2 * POS * (1 << STAGE);
            ntt8_butterfly #(.SHIFT(SHAMT)) u_bf (
                .a   (din[LO]),
                .b   (din[HI]),
                .top (dout[LO]),
                .bot (dout[HI])
            );
        end
    endgenerate
endmodule

// File: rtl/ntt8_transform.sv
// Module: eight-point transform mod 257 with optional edge conversion,
// output ordering and output register. Assumes each input word is 0..256.
module ntt8_transform
    import ntt8_pkg::*;
#(
    parameter bit OUT_REG       = 1'b1,
    parameter bit NATURAL_ORDER = 1'b1,
    parameter bit ENC_IN        = 1'b1,
    parameter bit ENC_OUT       = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NPTS*WW-1:0]   in_data,
    output logic                 out_valid,
    output logic [NPTS*WW-1:0]   out_data
);
    vec_t raw_in;
    vec_t layer_v [LOGN+1];
    vec_t ordered;
    vec_t result;

    assign raw_in = in_data;

    // Edge conversion into complemented form, if selected.
    generate
        for (genvar j = 0; j < NPTS; j++) begin : g_in
            if (ENC_IN) begin : g_conv
                assign layer_v[0][j] = flip_enc(raw_in[j]);
            end else begin : g_pass
                assign layer_v[0][j] = raw_in[j];
            end
        end
    endgenerate

    // Three butterfly layers.
    generate
        for (genvar s = 0; s < LOGN; s++) begin : g_layer
            ntt8_layer #(.STAGE(s)) u_layer (
                .din  (layer_v[s]),
                .dout (layer_v[s+1])
            );
        end
    endgenerate

    // Output ordering and conversion back to plain values, if selected.
    generate
        for (genvar k = 0; k < NPTS; k++) begin : g_out
            localparam int SRC = NATURAL_ORDER ? bit_rev(k) : k;
            assign ordered[k] = layer_v[LOGN][SRC];
            if (ENC_OUT) begin : g_conv
                assign result[k] = flip_enc(ordered[k]);
            end else begin : g_pass
                assign result[k] = ordered[k];
            end
        end
    endgenerate

    // Optional output register, loaded only on valid input.
    generate
        if (OUT_REG) begin : g_reg
            logic  vld_q;
            vec_t  dat_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    dat_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) dat_q <= result;
                end
            end
            assign out_valid = vld_q;
            assign out_data  = dat_q;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_data  = result;
        end
    endgenerate
endmodule

// File: rtl/ntt8_checker.sv
// Module: temporal checks for ntt8_transform, attached by bind below.
module ntt8_checker
    import ntt8_pkg::*;
#(
    parameter bit OUT_REG = 1'b1,
    parameter bit ENC_IN  = 1'b1,
    parameter bit ENC_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [NPTS*WW-1:0] in_data,
    input logic               out_valid,
    input logic [NPTS*WW-1:0] out_data
);
    function automatic logic all_in_range(logic [NPTS*WW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < NPTS; j++) if (v[j*WW +: WW] > 9'd256) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [WW-1:0] dc_sum(logic [NPTS*WW-1:0] v);
        int acc;
        acc = 0;
        for (int j = 0; j < NPTS; j++) acc = (acc + int'(v[j*WW +: WW])) % 257;
        return WW'(acc);
    endfunction

    assert_out_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> all_in_range(out_data));

    generate
        if (OUT_REG) begin : g_seq
            assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(out_data));
            if (ENC_IN && ENC_OUT) begin : g_dc
                assert_dc_term_R1: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid |=> out_data[WW-1:0] == dc_sum($past(in_data)));
            end
        end
    endgenerate
endmodule

bind ntt8_transform ntt8_checker #(
    .OUT_REG (OUT_REG),
    .ENC_IN  (ENC_IN),
    .ENC_OUT (ENC_OUT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_ntt8_transform.sv
// Bench: behavioural reference (direct O(n^2) sums mod 257) compared every clock.
module sim_ntt8_transform;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int WD = 9;

    typedef int arr_t [NP];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NP*WD-1:0] in_data = '0;
    logic [NP*WD-1:0] u1_in;
    logic u0_vld, u1_vld;
    logic [NP*WD-1:0] u0_dat, u1_dat;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    logic cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntt8_transform u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(u0_vld), .out_data(u0_dat)
    );

    ntt8_transform #(.OUT_REG(1'b0), .NATURAL_ORDER(1'b0), .ENC_IN(1'b0), .ENC_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(u1_in),
        .out_valid(u1_vld), .out_data(u1_dat)
    );

    function automatic int rev3(int v);
        return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
    endfunction

    function automatic arr_t unpack_v(logic [NP*WD-1:0] v);
        arr_t a;
        for (int j = 0; j < NP; j++) a[j] = int'(v[j*WD +: WD]);
        return a;
    endfunction

    // Direct evaluation of the transform, term k = sum x[j]*4^(jk) mod 257.
    function automatic arr_t ref_xform(arr_t x);
        arr_t y;
        for (int k = 0; k < NP; k++) begin
            int acc;
            acc = 0;
            for (int j = 0; j < NP; j++) begin
                int p;
                p = 1;
                for (int e = 0; e < j * k; e++) p = (p * 4) % 257;
                acc = (acc + x[j] * p) % 257;
            end
            y[k] = acc;
        end
        return y;
    endfunction

    function automatic logic [NP*WD-1:0] exp_natural(logic [NP*WD-1:0] v);
        arr_t y;
        logic [NP*WD-1:0] r;
        y = ref_xform(unpack_v(v));
        for (int k = 0; k < NP; k++) r[k*WD +: WD] = WD'(y[k]);
        return r;
    endfunction

    // Complemented, bit-reversed expectation for the second instance (R3, R4).
    function automatic logic [NP*WD-1:0] exp_alt(logic [NP*WD-1:0] v);
        arr_t y;
        logic [NP*WD-1:0] r;
        y = ref_xform(unpack_v(v));
        for (int i = 0; i < NP; i++) r[i*WD +: WD] = WD'((256 - y[rev3(i)]) % 257);
        return r;
    endfunction

    always_comb begin
        for (int j = 0; j < NP; j++) u1_in[j*WD +: WD] = WD'((256 - int'(in_data[j*WD +: WD])) % 257);
    end

    // Reference model of the registered output.
    logic exp_v_q;
    logic [NP*WD-1:0] exp_d_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v_q <= 1'b0;
            exp_d_q <= '0;
        end else begin
            exp_v_q <= in_valid;
            if (in_valid) exp_d_q <= exp_natural(in_data);
        end
    end

    // Compare both instances against the model at every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (u0_vld !== exp_v_q || u0_dat !== exp_d_q) begin
                fails++;
                $display("FAIL %s,R2,R7 u0 actual=%b/%h expected=%b/%h", cur_req, u0_vld, u0_dat, exp_v_q, exp_d_q);
            end
            checks++;
            if (u1_vld !== in_valid || (in_valid && u1_dat !== exp_alt(in_data))) begin
                fails++;
                $display("FAIL %s,R3,R4 u1 actual=%b/%h expected=%b/%h", cur_req, u1_vld, u1_dat, in_valid, exp_alt(in_data));
            end
            if (u0_vld) begin
                for (int j = 0; j < NP; j++) begin
                    checks++;
                    if (u0_dat[j*WD +: WD] > 9'd256) begin
                        fails++;
                        $display("FAIL R6 word %0d actual=%0d expected<=256", j, u0_dat[j*WD +: WD]);
                    end
                end
            end
        end
    end

    task automatic send(input logic [NP*WD-1:0] v, input string req);
        @(posedge clk);
        #2;
        cur_req = req;
        in_valid = 1'b1;
        in_data = v;
    endtask

    task automatic idle(input logic [NP*WD-1:0] junk, input string req);
        @(posedge clk);
        #2;
        cur_req = req;
        in_valid = 1'b0;
        in_data = junk;
    endtask

    function automatic logic [NP*WD-1:0] one_word(int pos, int val);
        logic [NP*WD-1:0] r;
        r = '0;
        r[pos*WD +: WD] = WD'(val);
        return r;
    endfunction

    function automatic logic [NP*WD-1:0] rnd_vec();
        logic [NP*WD-1:0] r;
        for (int j = 0; j < NP; j++) r[j*WD +: WD] = WD'($urandom_range(256, 0));
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NP*WD-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: register cleared during reset.
        checks++;
        if (u0_vld !== 1'b0 || u0_dat !== '0) begin
            fails++;
            $display("FAIL R9 actual=%b/%h expected=0/0", u0_vld, u0_dat);
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: all-zero vector and single impulses (unit value) per position; R2 lanes.
        send('0, "R1");
        for (int p = 0; p < NP; p++) send(one_word(p, 1), "R2");
        for (int p = 0; p < NP; p++) send(one_word(p, 3), "R1");
        // R5: value 256 in each position, alone and over a random background.
        for (int p = 0; p < NP; p++) send(one_word(p, 256), "R5");
        for (int p = 0; p < NP; p++) begin
            v = rnd_vec();
            v[p*WD +: WD] = 9'd256;
            send(v, "R5");
        end
        v = '0;
        for (int j = 0; j < NP; j++) v[j*WD +: WD] = 9'd256;
        send(v, "R5");
        // R8: idle cycles with junk inputs must not disturb the held result.
        idle(rnd_vec(), "R8");
        idle(rnd_vec(), "R8");
        idle(v ^ {NP*WD{1'b1}}, "R8");
        // R1 and R7: back-to-back random vectors with idle gaps.
        for (int n = 0; n < 60; n++) begin
            send(rnd_vec(), "R1");
            if (n % 7 == 3) idle(rnd_vec(), "R7");
        end
        idle('0, "R7");
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule